// File: doc/BRIEF.md
# Coalescing Delayed-Drain Store Buffer

This block sits between a processor core and the memory system. It holds committed stores instead of sending each one out straight away. A store to a cache line that already has an entry is folded into that entry under a per-byte enable mask, so several writes to one line cost a single memory request. Buffered lines leave as a burst of line-sized requests. A burst starts when a store to a new line finds every entry taken, or when the core asks for a synchronization point. The synchronization handshake completes only once every line has been issued and acknowledged by memory.

Loads never wait behind buffered stores. The load port looks up the buffer combinationally. When every byte of the addressed word is buffered, it reports a hit and returns the buffered word. Otherwise the core presents the word it fetched from memory, and the buffered bytes are laid over it. A mode input selects the issue discipline. In partial-store-order mode up to `MAX_OUT` requests may be in flight and an unacknowledged older line does not hold back younger ones. In total-store-order mode lines leave one at a time, oldest first.

A control state machine has three states. FILL accepts and merges stores. DRAIN issues entries in allocation order and collects acknowledgements. SYNC_ACK raises the synchronization acknowledge for one cycle. The transitions are:
- GO_SYNC: FILL to DRAIN on a sync request.
- GO_FULL: FILL to DRAIN when a store to a new line meets a full buffer.
- DONE_RESUME: DRAIN to FILL when every entry is acknowledged and no sync request is pending.
- DONE_ACK: DRAIN to SYNC_ACK when every entry is acknowledged and a sync request is pending.
- RELEASE: SYNC_ACK to FILL.

Top module: `sb_store_buffer`

## Requirements
- R1: While the buffer is in FILL, `mreq_valid` stays 0. Accepted stores produce no memory request until a drain trigger.
- R2: A store to a line absent from the buffer, arriving while all `NUM_ENT` entries are valid, sees `st_ready`=0 and starts a drain with no sync request. After the drain it is accepted into entry 0 (`mreq_tag`=0 on the next drain).
- R3: A raised `sync_req` starts a drain. `sync_ack` is a one-cycle pulse, given only after every issued line has been acknowledged, with `idle`=1 while it is high.
- R4: A store whose line (address bits [31:5]) matches a valid entry merges into it. Only the enabled bytes change, and their enables are ORed into the entry mask. Byte b of the line is `mreq_data[8b+7:8b]` and `mreq_be[b]`; the word offset is address bits [4:2]; `st_be[k]` covers byte k of the word.
- R5: A load whose word has all four bytes enabled in a valid entry gives `ld_hit`=1 and the buffered word on `ld_data` in the same cycle.
- R6: Otherwise `ld_hit`=0, and `ld_data` is `ld_mem_data` with every buffered byte of that word substituted.
- R7: With `pso_mode`=1 at most `MAX_OUT` (4) requests are outstanding, and an acknowledge for any one of them lets the next entry issue even while older ones remain unacknowledged.
- R8: With `pso_mode`=0 at most one request is outstanding, and tags issue in increasing entry order.
- R9: `st_ready` is 0 throughout DRAIN and SYNC_ACK.
- R10: Each request carries its entry index on `mreq_tag`, which stays stable while stalled. An acknowledge with that tag frees the entry. `idle` is 1 exactly when no entry is valid and nothing is outstanding.
- R11: Reset clears all entries and ends any drain: afterwards `idle`=1, `st_ready`=1, `mreq_valid`=0 and earlier stores no longer hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pso_mode | input | 1 | 1 = partial store order issue, 0 = total store order issue |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | 32 | Store byte address (word aligned) |
| st_data | input | 32 | Store word |
| st_be | input | 4 | Store byte enables |
| ld_addr | input | 32 | Load byte address (word aligned) |
| ld_mem_data | input | 32 | Word returned by memory for the load |
| ld_hit | output | 1 | Whole word is buffered |
| ld_data | output | 32 | Load word with buffered bytes overlaid |
| sync_req | input | 1 | Synchronization request, held until acknowledged |
| sync_ack | output | 1 | One-cycle acknowledge once the buffer is empty |
| mreq_valid | output | 1 | Line request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_line | output | 27 | Line address (byte address bits [31:5]) |
| mreq_data | output | 256 | Line data |
| mreq_be | output | 32 | Line byte enables |
| mreq_tag | output | 3 | Entry index of the request |
| mack_valid | input | 1 | Completion acknowledge |
| mack_tag | input | 3 | Entry index being acknowledged |
| idle | output | 1 | No valid entry and no outstanding request |

## Verification
The bench walks a table of stores and loads that first hits a fresh word, then merges a single byte into it, and then probes a partially covered word and an uncovered word of a buffered line. A design that replaced the whole word on merge, or that reported a hit on partial coverage, returns the wrong word or the wrong hit flag. Partial-store-order draining is checked by withholding the acknowledge for the oldest line and acknowledging a younger one. A design that capped the burst wrongly or retired strictly in order issues the wrong number of requests. Total-store-order draining is checked for exactly one outstanding request. The full-buffer case checks that the ninth distinct line stalls, drains the buffer without a sync request and then lands in entry 0. A reset taken with data buffered must leave nothing to forward.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        PH_FILL     = 2'd0,
        PH_DRAIN    = 2'd1,
        PH_SYNC_ACK = 2'd2
    } sb_phase_e;
endpackage

// File: rtl/sb_line_store.sv
module sb_line_store #(
    parameter int NUM_ENT    = 8,
    parameter int LINE_AW    = 27,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int WOFF_W = $clog2(LINE_BYTES / WORD_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_new,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [LINE_AW-1:0]        st_line,
    input  logic [WOFF_W-1:0]         st_word,
    input  logic [8*WORD_BYTES-1:0]   st_data,
    input  logic [WORD_BYTES-1:0]     st_be,
    output logic                      st_hit,
    output logic [IDX_W-1:0]          st_hit_idx,
    input  logic                      clr_en,
    input  logic [IDX_W-1:0]          clr_idx,
    input  logic [LINE_AW-1:0]        ld_line,
    input  logic [WOFF_W-1:0]         ld_word,
    input  logic [8*WORD_BYTES-1:0]   ld_mem_data,
    output logic                      ld_hit,
    output logic [8*WORD_BYTES-1:0]   ld_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [LINE_AW-1:0]        rd_line,
    output logic [8*LINE_BYTES-1:0]   rd_data,
    output logic [LINE_BYTES-1:0]     rd_be,
    output logic                      any_valid
);
    logic [NUM_ENT-1:0]    vld_q;
    logic [LINE_AW-1:0]    line_q [NUM_ENT];
    logic [LINE_BYTES-1:0] be_q   [NUM_ENT];
    logic [7:0]            byte_q [NUM_ENT][LINE_BYTES];

    logic [LINE_BYTES-1:0] wr_mask;
    logic                  ld_match;
    logic [IDX_W-1:0]      ld_idx;

    assign wr_mask   = LINE_BYTES'(st_be) << (int'(st_word) * WORD_BYTES);
    assign any_valid = |vld_q;

    always_comb begin
        st_hit     = 1'b0;
        st_hit_idx = '0;
        ld_match   = 1'b0;
        ld_idx     = '0;
        for (int e = 0; e < NUM_ENT; e++) begin
            if (vld_q[e] && line_q[e] == st_line) begin
                st_hit     = 1'b1;
                st_hit_idx = IDX_W'(e);
            end
            if (vld_q[e] && line_q[e] == ld_line) begin
                ld_match = 1'b1;
                ld_idx   = IDX_W'(e);
            end
        end
    end

    always_comb begin
        ld_hit = ld_match;
        for (int k = 0; k < WORD_BYTES; k++) begin
            if (ld_match && be_q[ld_idx][int'(ld_word) * WORD_BYTES + k]) begin
                ld_data[8*k +: 8] = byte_q[ld_idx][int'(ld_word) * WORD_BYTES + k];
            end else begin
                ld_data[8*k +: 8] = ld_mem_data[8*k +: 8];
                ld_hit            = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (clr_en)          vld_q[clr_idx] <= 1'b0;
            if (wr_en && wr_new) vld_q[wr_idx]  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_new) begin
                line_q[wr_idx] <= st_line;
                be_q[wr_idx]   <= wr_mask;
            end else begin
                be_q[wr_idx]   <= be_q[wr_idx] | wr_mask;
            end
            for (int b = 0; b < LINE_BYTES; b++) begin
                if (wr_mask[b]) byte_q[wr_idx][b] <= st_data[8*(b % WORD_BYTES) +: 8];
            end
        end
    end

    always_comb begin
        rd_line = line_q[rd_idx];
        rd_be   = be_q[rd_idx];
        for (int b = 0; b < LINE_BYTES; b++) rd_data[8*b +: 8] = byte_q[rd_idx][b];
    end
endmodule

// File: rtl/sb_drain_ctl.sv
module sb_drain_ctl
    import sb_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int MAX_OUT = 4,
    localparam int IDX_W = $clog2(NUM_ENT),
    localparam int CNT_W = $clog2(NUM_ENT + 1),
    localparam int OUT_W = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pso_mode,
    input  logic             st_valid,
    input  logic             st_hit,
    input  logic             sync_req,
    input  logic             mreq_ready,
    input  logic             mack_valid,
    output logic             st_ready,
    output logic             wr_en,
    output logic             wr_new,
    output logic [IDX_W-1:0] alloc_idx,
    output logic [IDX_W-1:0] issue_idx,
    output logic             mreq_valid,
    output logic             sync_ack,
    output logic             out_zero
);
    sb_phase_e        phase_q, phase_d;
    logic [CNT_W-1:0] alloc_q, iss_q;
    logic [OUT_W-1:0] out_q, out_lim;
    logic             full, drain_done, issue_fire;

    assign full       = alloc_q == CNT_W'(NUM_ENT);
    assign out_lim    = pso_mode ? OUT_W'(MAX_OUT) : OUT_W'(1);
    assign drain_done = phase_q == PH_DRAIN && iss_q == alloc_q && out_q == '0;
    assign issue_fire = mreq_valid && mreq_ready;

    // next-state: GO_SYNC, GO_FULL, DONE_ACK, DONE_RESUME, RELEASE
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_FILL: begin
                if (sync_req || (st_valid && !st_hit && full)) phase_d = PH_DRAIN;
            end
            PH_DRAIN: begin
                if (drain_done) phase_d = sync_req ? PH_SYNC_ACK : PH_FILL;
            end
            PH_SYNC_ACK: phase_d = PH_FILL;
            default:     phase_d = PH_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_FILL;
            alloc_q <= '0;
            iss_q   <= '0;
            out_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (drain_done) begin
                alloc_q <= '0;
                iss_q   <= '0;
            end else begin
                if (wr_en && wr_new) alloc_q <= alloc_q + 1'b1;
                if (issue_fire)      iss_q   <= iss_q + 1'b1;
            end
            out_q <= out_q + OUT_W'(issue_fire) - OUT_W'(mack_valid);
        end
    end

    always_comb begin
        st_ready   = 1'b0;
        mreq_valid = 1'b0;
        sync_ack   = 1'b0;
        unique case (phase_q)
            PH_FILL:     st_ready   = !sync_req && !(!st_hit && full);
            PH_DRAIN:    mreq_valid = (iss_q < alloc_q) && (out_q < out_lim);
            PH_SYNC_ACK: sync_ack   = 1'b1;
            default:     st_ready   = 1'b0;
        endcase
        wr_en     = st_valid && st_ready;
        wr_new    = !st_hit;
        alloc_idx = alloc_q[IDX_W-1:0];
        issue_idx = iss_q[IDX_W-1:0];
        out_zero  = out_q == '0;
    end
endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer #(
    parameter int NUM_ENT    = 8,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4,
    parameter int MAX_OUT    = 4,
    localparam int IDX_W   = $clog2(NUM_ENT),
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int WB_W    = $clog2(WORD_BYTES),
    localparam int LINE_AW = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pso_mode,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [8*WORD_BYTES-1:0] st_data,
    input  logic [WORD_BYTES-1:0]   st_be,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [8*WORD_BYTES-1:0] ld_mem_data,
    output logic                    ld_hit,
    output logic [8*WORD_BYTES-1:0] ld_data,
    input  logic                    sync_req,
    output logic                    sync_ack,
    output logic                    mreq_valid,
    input  logic                    mreq_ready,
    output logic [LINE_AW-1:0]      mreq_line,
    output logic [8*LINE_BYTES-1:0] mreq_data,
    output logic [LINE_BYTES-1:0]   mreq_be,
    output logic [IDX_W-1:0]        mreq_tag,
    input  logic                    mack_valid,
    input  logic [IDX_W-1:0]        mack_tag,
    output logic                    idle
);
    logic             st_hit, wr_en, wr_new, any_valid, out_zero;
    logic [IDX_W-1:0] st_hit_idx, alloc_idx, issue_idx;
    logic             unused_lo;

    assign unused_lo = ^{st_addr[WB_W-1:0], ld_addr[WB_W-1:0]};
    assign mreq_tag  = issue_idx;
    assign idle      = !any_valid && out_zero;

    sb_drain_ctl #(.NUM_ENT(NUM_ENT), .MAX_OUT(MAX_OUT)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pso_mode   (pso_mode),
        .st_valid   (st_valid),
        .st_hit     (st_hit),
        .sync_req   (sync_req),
        .mreq_ready (mreq_ready),
        .mack_valid (mack_valid),
        .st_ready   (st_ready),
        .wr_en      (wr_en),
        .wr_new     (wr_new),
        .alloc_idx  (alloc_idx),
        .issue_idx  (issue_idx),
        .mreq_valid (mreq_valid),
        .sync_ack   (sync_ack),
        .out_zero   (out_zero)
    );

    sb_line_store #(
        .NUM_ENT(NUM_ENT), .LINE_AW(LINE_AW),
        .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)
    ) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_new      (wr_new),
        .wr_idx      (wr_new ? alloc_idx : st_hit_idx),
        .st_line     (st_addr[ADDR_W-1:OFF_W]),
        .st_word     (st_addr[OFF_W-1:WB_W]),
        .st_data     (st_data),
        .st_be       (st_be),
        .st_hit      (st_hit),
        .st_hit_idx  (st_hit_idx),
        .clr_en      (mack_valid),
        .clr_idx     (mack_tag),
        .ld_line     (ld_addr[ADDR_W-1:OFF_W]),
        .ld_word     (ld_addr[OFF_W-1:WB_W]),
        .ld_mem_data (ld_mem_data),
        .ld_hit      (ld_hit),
        .ld_data     (ld_data),
        .rd_idx      (issue_idx),
        .rd_line     (mreq_line),
        .rd_data     (mreq_data),
        .rd_be       (mreq_be),
        .any_valid   (any_valid)
    );
endmodule

// File: rtl/sb_store_buffer_chk.sv
module sb_store_buffer_chk #(
    parameter int MAX_OUT = 4,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pso_mode,
    input logic             st_ready,
    input logic             sync_ack,
    input logic             mreq_valid,
    input logic             mreq_ready,
    input logic [IDX_W-1:0] mreq_tag,
    input logic             mack_valid,
    input logic             idle
);
    logic [7:0] chk_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_out <= '0;
        else        chk_out <= chk_out + 8'(mreq_valid && mreq_ready) - 8'(mack_valid);
    end

    p_hold_in_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> !mreq_valid);
    p_ack_when_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ack |-> idle);
    p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ack |=> !sync_ack);
    p_out_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> chk_out < 8'(MAX_OUT));
    p_tso_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !pso_mode) |-> chk_out == 8'd0);
    p_stall_in_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ack |-> !st_ready);
    p_tag_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_tag)));
    p_idle_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> chk_out == 8'd0);
endmodule

bind sb_store_buffer sb_store_buffer_chk #(.MAX_OUT(MAX_OUT), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pso_mode   (pso_mode),
    .st_ready   (st_ready),
    .sync_ack   (sync_ack),
    .mreq_valid (mreq_valid),
    .mreq_ready (mreq_ready),
    .mreq_tag   (mreq_tag),
    .mack_valid (mack_valid),
    .idle       (idle)
);

// File: tb/sim_sb_store_buffer.sv
`timescale 1ns/1ps
module sim_sb_store_buffer;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         pso_mode = 1;
    logic         st_valid = 0;
    logic         st_ready;
    logic [31:0]  st_addr = 0, st_data = 0;
    logic [3:0]   st_be = 0;
    logic [31:0]  ld_addr = 0, ld_mem_data = 0;
    logic         ld_hit;
    logic [31:0]  ld_data;
    logic         sync_req = 0, sync_ack;
    logic         mreq_valid, mreq_ready = 1;
    logic [26:0]  mreq_line;
    logic [255:0] mreq_data;
    logic [31:0]  mreq_be;
    logic [2:0]   mreq_tag;
    logic         mack_valid = 0;
    logic [2:0]   mack_tag = 0;
    logic         idle;

    always #10 clk = ~clk;

    sb_store_buffer u0 (.*);

    int n_chk = 0, n_err = 0;
    int rq_n = 0;
    logic [2:0]   rq_tag  [64];
    logic [26:0]  rq_line [64];
    logic [31:0]  rq_be   [64];
    logic [255:0] rq_data [64];
    logic watch = 0, saw_req = 0;

    always @(negedge clk) begin
        #2;
        if (rst_n && mreq_valid && mreq_ready && rq_n < 64) begin
            rq_tag[rq_n]  = mreq_tag;
            rq_line[rq_n] = mreq_line;
            rq_be[rq_n]   = mreq_be;
            rq_data[rq_n] = mreq_data;
            rq_n++;
        end
        if (watch && mreq_valid) saw_req = 1;
    end

    typedef struct packed {
        logic        is_ld;
        logic [31:0] addr;
        logic [31:0] dat;
        logic [3:0]  be;
        logic        exp_hit;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 32'h100, 32'h11223344, 4'hF, 1'b0, 32'h0},
        '{1'b1, 32'h100, 32'hAAAAAAAA, 4'h0, 1'b1, 32'h11223344},
        '{1'b0, 32'h100, 32'h000000FF, 4'h1, 1'b0, 32'h0},
        '{1'b1, 32'h100, 32'hAAAAAAAA, 4'h0, 1'b1, 32'h112233FF},
        '{1'b0, 32'h124, 32'h55667788, 4'hC, 1'b0, 32'h0},
        '{1'b1, 32'h124, 32'hDEADBEEF, 4'h0, 1'b0, 32'h5566BEEF},
        '{1'b1, 32'h200, 32'h12345678, 4'h0, 1'b0, 32'h12345678},
        '{1'b1, 32'h104, 32'hCAFEF00D, 4'h0, 1'b0, 32'hCAFEF00D}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
        st_valid = 1; st_addr = a; st_data = d; st_be = b;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        st_valid = 0;
    endtask

    task automatic do_ack(input logic [2:0] t);
        mack_valid = 1; mack_tag = t;
        @(negedge clk);
        mack_valid = 0;
    endtask

    task automatic wait_reqs(input int want);
        while (rq_n < want) begin @(negedge clk); #3; end
    endtask

    task automatic end_sync();
        #1;
        chk(sync_ack == 0, "R3 ack not before last ack lands", 64'(sync_ack), 0);
        @(negedge clk); #1;
        chk(sync_ack == 1, "R3 ack after buffer empty", 64'(sync_ack), 1);
        chk(st_ready == 0, "R9 stall while acknowledging", 64'(st_ready), 0);
        sync_req = 0;
        @(negedge clk); #1;
        chk(sync_ack == 0 && idle == 1, "R3 one-cycle ack then idle (R10)", {sync_ack, idle}, 64'b01);
    endtask

    task automatic run_all();
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(idle && st_ready && !mreq_valid && !sync_ack, "R11 reset state",
            {idle, st_ready, mreq_valid, sync_ack}, 64'b1100);

        // table walk: merging and forwarding (R4 R5 R6), no requests (R1)
        watch = 1;
        for (int i = 0; i < 8; i++) begin
            vec_t v = VECS[i];
            if (!v.is_ld) begin
                do_store(v.addr, v.dat, v.be);
            end else begin
                ld_addr = v.addr; ld_mem_data = v.dat;
                #1;
                chk(ld_hit == v.exp_hit, $sformatf("R5/R6 vector %0d hit", i), 64'(ld_hit), 64'(v.exp_hit));
                chk(ld_data == v.exp, $sformatf("R4/R5/R6 vector %0d data", i), 64'(ld_data), 64'(v.exp));
                @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        watch = 0;
        chk(saw_req == 0, "R1 no request while filling", 64'(saw_req), 0);

        // sync drain of merged lines
        base = rq_n;
        sync_req = 1;
        wait_reqs(base + 2);
        chk(rq_tag[base] == 0 && rq_line[base] == 27'h8, "R10 first request tag/line",
            {rq_tag[base], rq_line[base]}, {3'd0, 27'h8});
        chk(rq_be[base] == 32'h0000000F && rq_data[base][31:0] == 32'h112233FF, "R4 merged line 8",
            {rq_be[base], rq_data[base][31:0]}, {32'hF, 32'h112233FF});
        chk(rq_tag[base+1] == 1 && rq_be[base+1] == 32'h000000C0 && rq_data[base+1][63:48] == 16'h5566,
            "R4 partial line 9", {rq_tag[base+1], rq_be[base+1], rq_data[base+1][63:48]},
            {3'd1, 32'hC0, 16'h5566});
        chk(st_ready == 0, "R9 stall in drain", 64'(st_ready), 0);
        do_ack(0);
        do_ack(1);
        end_sync();

        // partial store order: cap and no head blocking (R7)
        for (int i = 0; i < 5; i++) do_store(32'h400 + 32'(i * 32), 32'(i), 4'hF);
        base = rq_n;
        sync_req = 1;
        repeat (10) @(negedge clk);
        #3;
        chk(rq_n - base == 4, "R7 four outstanding", 64'(rq_n - base), 4);
        do_ack(1);
        repeat (3) @(negedge clk);
        #3;
        chk(rq_n - base == 5 && rq_tag[base+4] == 4, "R7 younger issues past unacked oldest",
            {32'(rq_n - base), 32'(rq_tag[base+4])}, {32'd5, 32'd4});
        do_ack(0);
        #1;
        chk(sync_ack == 0, "R3 no ack with lines outstanding", 64'(sync_ack), 0);
        do_ack(2); do_ack(3); do_ack(4);
        end_sync();

        // total store order (R8)
        pso_mode = 0;
        for (int i = 0; i < 3; i++) do_store(32'h800 + 32'(i * 32), 32'(i), 4'hF);
        base = rq_n;
        sync_req = 1;
        for (int k = 0; k < 3; k++) begin
            repeat (6) @(negedge clk);
            #3;
            chk(rq_n - base == k + 1 && rq_tag[base+k] == 3'(k), "R8 one at a time, oldest first",
                {32'(rq_n - base), 32'(rq_tag[base+k])}, {32'(k + 1), 32'(k)});
            do_ack(3'(k));
        end
        end_sync();
        pso_mode = 1;

        // full buffer trigger (R2)
        for (int i = 0; i < 8; i++) do_store(32'h1000 + 32'(i * 32), 32'(i), 4'hF);
        base = rq_n;
        st_valid = 1; st_addr = 32'h2000; st_data = 32'hABCD0123; st_be = 4'hF;
        #1;
        chk(st_ready == 0, "R2 new line stalls on full buffer", 64'(st_ready), 0);
        repeat (2) @(negedge clk);
        #3;
        chk(rq_n > base && st_ready == 0, "R2 drain starts without sync (R9)",
            {32'(rq_n - base), 32'(st_ready)}, {32'd1, 32'd0});
        fork
            do_store(32'h2000, 32'hABCD0123, 4'hF);
            begin
                for (int k = 0; k < 8; k++) begin
                    wait_reqs(base + k + 1);
                    do_ack(rq_tag[base+k]);
                end
            end
        join
        ld_addr = 32'h2000; ld_mem_data = 0;
        #1;
        chk(ld_hit && ld_data == 32'hABCD0123, "R2 stalled store accepted after drain",
            {ld_hit, ld_data}, {1'b1, 32'hABCD0123});
        base = rq_n;
        sync_req = 1;
        wait_reqs(base + 1);
        chk(rq_tag[base] == 0 && rq_line[base] == 27'h100, "R2 store landed in entry 0",
            {rq_tag[base], rq_line[base]}, {3'd0, 27'h100});
        do_ack(0);
        end_sync();

        // reset with data buffered (R11)
        do_store(32'h300, 32'h0BADF00D, 4'hF);
        ld_addr = 32'h300; ld_mem_data = 0;
        #1;
        chk(ld_hit == 1 && idle == 0, "R11 data buffered before reset", {ld_hit, idle}, 64'b10);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1;
        chk(idle && !ld_hit && st_ready && !mreq_valid, "R11 reset clears entries",
            {idle, ld_hit, st_ready, mreq_valid}, 64'b1010);
        @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule